// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a byte-oriented SPI master that a processor programs through three byte registers: control, status and data. The processor sets clock polarity, clock phase, bit order and the serial clock rate in the control register, then writes a byte to the data register. That write starts an eight-bit full-duplex exchange. The byte goes out on `mosi` while eight bits are taken in from `miso`. The serial clock is a divided copy of the system clock.

When the exchange ends, the received byte replaces the contents of the data register and a completion flag is set in the status register. The completion flag can raise an interrupt request. A data write that arrives while an exchange is running is refused and sets a collision flag. A data write made while the block is disabled has no effect at all. The completion flag clears when the interrupt is acknowledged or when a new exchange is accepted.

Register addresses: 0 is control, 1 is status, 2 is data, and 3 reads as zero.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, every register reads zero, `sclk` is low, `mosi` is low and `irq` is low.
- R2: The control register at address 0 reads back exactly as written. Its bits are: bit 7 interrupt enable, bit 6 enable, bit 5 bit order (1 = LSB first), bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate select.
- R3: The clock divider is a base of 4, or 2 when double speed is set, multiplied by 1, 4, 16 or 32 for rate select 0, 1, 2 or 3. The completion flag (status bit 7) reads 0 after 8 × divider − 1 clock edges counted from the edge that accepts the data write, and reads 1 after 8 × divider edges.
- R4: `sclk` rests at the clock polarity level when idle. It makes exactly 16 transitions per exchange and ends at the idle level.
- R5: With clock phase 0, `mosi` holds the first bit before the first `sclk` transition, and both sides sample on leading transitions. With clock phase 1, both sides sample on trailing transitions. Both phases work under either polarity.
- R6: With bit order 0, bit 7 is sent first and the first bit received lands in bit 7. With bit order 1, bit 0 is sent first and the first bit received lands in bit 0.
- R7: At the end of an exchange, the data register (address 2) holds the byte received on `miso`, and the completion flag is set.
- R8: A data write while enable (control bit 6) is clear starts no exchange, leaves `sclk` idle and leaves the data and status registers unchanged.
- R9: A data write during an exchange sets the collision flag (status bit 6). The running exchange still sends the original byte and receives the correct byte.
- R10: An accepted data write clears both the collision flag and the completion flag.
- R11: `irq` is high exactly when interrupt enable and the completion flag are both set. A one-cycle pulse on `irqAck` clears the completion flag.
- R12: A status write changes only the double-speed bit (status bit 0). The two flags cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read of the selected register |
| irqAck | input | 1 | One-cycle interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs six configurations that cover all four polarity and phase combinations, both bit orders and dividers from 2 to 128. It plays the slave side at the pins and checks each bit that crosses, so a design that samples on the wrong transition or shifts in the wrong direction returns a scrambled byte. It checks the completion flag one edge before and on the exact edge the divider predicts, which exposes an off-by-one prescaler or a missing double-speed halving. Directed tests then cover the following:
- a data write in mid-exchange, which a faulty design would let restart or corrupt the shifter;
- a data write while disabled, which a faulty design would accept;
- clearing the flags on acknowledge and on a new write;
- attempts to write the read-only flag bits.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 7;                      // holds the largest half period (64)
  localparam int EDGES   = 2 * BYTE_W;             // sclk transitions per byte
  localparam int EDGE_W  = $clog2(EDGES);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control bit positions
  localparam int CB_IRQEN = 7;
  localparam int CB_EN    = 6;
  localparam int CB_LSBF  = 5;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 2;

  typedef struct packed {
    logic load;
    logic sclkEdge;
    logic sample;
    logic shift;
    logic finish;
  } spimStrobes_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              irqAck,
  output logic [BYTE_W-1:0] ctrlByte,
  output logic [BYTE_W-1:0] statByte,
  output logic              irq,
  output spimStrobes_t      stb
);
  logic [BYTE_W-1:0] ctrlReg;
  logic              dblSpeed, doneFlag, collFlag, busy;
  logic [HALF_W-1:0] halfSel, halfLat, halfCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic              dataWr, accept, collide, edgeNow, finishNow, cpha;

  assign cpha    = ctrlReg[CB_CPHA];
  assign dataWr  = regWrEn && (regAddr == ADDR_DATA) && ctrlReg[CB_EN];
  assign accept  = dataWr && !busy;
  assign collide = dataWr && busy;

  always_comb begin
    logic [HALF_W-1:0] baseHalf;
    baseHalf = dblSpeed ? HALF_W'(1) : HALF_W'(2);
    case (ctrlReg[1:0])
      2'd0:    halfSel = baseHalf;
      2'd1:    halfSel = baseHalf << 2;
      2'd2:    halfSel = baseHalf << 4;
      default: halfSel = baseHalf << 5;
    endcase
  end

  assign edgeNow   = busy && (halfCnt == halfLat - HALF_W'(1));
  assign finishNow = edgeNow && (edgeIdx == EDGE_W'(EDGES - 1));

  always_comb begin
    stb.load     = accept;
    stb.sclkEdge = edgeNow;
    stb.finish   = finishNow;
    stb.sample   = edgeNow && (edgeIdx[0] == cpha);
    if (cpha)
      stb.shift = (edgeNow && !edgeIdx[0] && (edgeIdx != '0)) || finishNow;
    else
      stb.shift = edgeNow && edgeIdx[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      dblSpeed <= 1'b0;
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      busy     <= 1'b0;
      halfLat  <= HALF_W'(1);
      halfCnt  <= '0;
      edgeIdx  <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) ctrlReg  <= regWrData;
      if (regWrEn && regAddr == ADDR_STAT) dblSpeed <= regWrData[0];

      if (finishNow)             doneFlag <= 1'b1;
      else if (accept || irqAck) doneFlag <= 1'b0;

      if (collide)     collFlag <= 1'b1;
      else if (accept) collFlag <= 1'b0;

      if (accept) begin
        busy    <= 1'b1;
        halfLat <= halfSel;
        halfCnt <= '0;
        edgeIdx <= '0;
      end else if (busy) begin
        if (edgeNow) begin
          halfCnt <= '0;
          edgeIdx <= edgeIdx + EDGE_W'(1);
          if (finishNow) busy <= 1'b0;
        end else begin
          halfCnt <= halfCnt + HALF_W'(1);
        end
      end
    end
  end

  assign ctrlByte = ctrlReg;
  assign statByte = {doneFlag, collFlag, {(BYTE_W-3){1'b0}}, dblSpeed};
  assign irq      = ctrlReg[CB_IRQEN] && doneFlag;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !finishNow) |=> !doneFlag);                      // R11
  AST_COLLIDE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    collide |=> (collFlag && busy));                            // R9
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DATA && !ctrlReg[CB_EN] && !busy) |=> !busy); // R8
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    finishNow |=> (doneFlag && !busy));                         // R7
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (!collFlag && !doneFlag));                       // R10
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobes_t      stb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              cpol,
  input  logic              lsbFirst,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] dataByte
);
  logic [BYTE_W-1:0] shiftReg;
  logic              rxBit, level, inBit;

  assign inBit = stb.sample ? miso : rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBit    <= 1'b0;
      level    <= 1'b0;
    end else begin
      if (stb.load)
        shiftReg <= wrData;
      else if (stb.shift)
        shiftReg <= lsbFirst ? {inBit, shiftReg[BYTE_W-1:1]}
                             : {shiftReg[BYTE_W-2:0], inBit};
      if (stb.sample) rxBit <= miso;
      if (stb.load)          level <= 1'b0;
      else if (stb.sclkEdge) level <= ~level;
    end
  end

  assign sclk     = cpol ^ level;
  assign mosi     = lsbFirst ? shiftReg[0] : shiftReg[BYTE_W-1];
  assign dataByte = shiftReg;

  AST_IDLE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !level);                                     // R4
  AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.shift) |=> $stable(shiftReg));           // R9
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       irqAck,
  output logic       irq,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  spimStrobes_t      stb;
  logic [BYTE_W-1:0] ctrlByte, statByte, dataByte;

  spim_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .irqAck(irqAck), .ctrlByte(ctrlByte),
    .statByte(statByte), .irq(irq), .stb(stb)
  );

  spim_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .cpol(ctrlByte[CB_CPOL]), .lsbFirst(ctrlByte[CB_LSBF]), .miso(miso),
    .sclk(sclk), .mosi(mosi), .dataByte(dataByte)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlByte;
      ADDR_STAT: regRdData = statByte;
      ADDR_DATA: regRdData = dataByte;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: tb/tb_spi_master_regs.sv
module tb_spi_master_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqAck = 1'b0;
  logic       irq, sclk, mosi;
  logic       miso = 1'b0;
  int         testCount = 0;
  int         failCount = 0;

  spi_master_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {cpol, cpha, lsbFirst, rate[1:0], dbl, tx[7:0], slave[7:0]}
  localparam logic [21:0] VECS [0:5] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 8'h96, 8'hE1},
    {1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 8'h0F, 8'h81},
    {1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 8'hC3, 8'h5A},
    {1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 8'h01, 8'hFE},
    {1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 8'h80, 8'h7F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int i, input logic lsbf);
    return lsbf ? b[i] : b[7-i];
  endfunction

  // one full exchange with a slave model played at the pins
  task automatic xfer(input logic [7:0] ctrlV, input logic dblV, input logic [7:0] txV,
                      input logic [7:0] slV, input bit injectCollide);
    int div, edges, misoIdx, sampIdx;
    logic prevS, prevM, cphaV, lsbf, cpolV;
    logic [7:0] got, rd;
    cpolV = ctrlV[3]; cphaV = ctrlV[2]; lsbf = ctrlV[5];
    div = (dblV ? 2 : 4) * ((ctrlV[1:0] == 2'd0) ? 1 : (ctrlV[1:0] == 2'd1) ? 4 :
                            (ctrlV[1:0] == 2'd2) ? 16 : 32);
    regWrite(2'd1, {7'd0, dblV});
    regWrite(2'd0, ctrlV);
    check("R4 idle level", sclk, cpolV);
    if (!cphaV) begin miso = bitOf(slV, 0, lsbf); misoIdx = 1; end
    else misoIdx = 0;
    regWrite(2'd2, txV);
    regRead(2'd1, rd);
    check("R10 flags cleared on accept", rd[7:6], 2'b00);
    check("R5 first bit on mosi", mosi, bitOf(txV, 0, lsbf));
    prevS = sclk; prevM = mosi; edges = 0; sampIdx = 0; got = '0;
    for (int count = 1; count <= 8*div; count++) begin
      @(negedge clk);
      if (injectCollide) begin
        if (count == 3) begin
          regAddr = 2'd2; regWrData = 8'hFF; regWrEn = 1'b1;
        end else if (count == 4) begin
          regWrEn = 1'b0; regAddr = 2'd1;
        end
      end
      if (sclk !== prevS) begin
        edges++;
        if ((edges % 2 == 1) == (cphaV == 1'b0)) begin
          if (sampIdx < 8) got[sampIdx] = prevM;
          sampIdx++;
        end else if (misoIdx < 8) begin
          miso = bitOf(slV, misoIdx, lsbf);
          misoIdx++;
        end
      end
      prevS = sclk; prevM = mosi;
      if (count == 8*div - 1) begin
        regRead(2'd1, rd);
        check("R3 flag low one edge early", rd[7], 1'b0);
      end
    end
    regRead(2'd1, rd);
    check("R3 flag set on exact edge", rd[7], 1'b1);
    check("R9 collision flag", rd[6], injectCollide);
    check("R4 transition count", edges, 16);
    check("R4 back to idle", sclk, cpolV);
    for (int i = 0; i < 8; i++)
      check("R5 R6 mosi bit seen by slave", got[i], bitOf(txV, i, lsbf));
    regRead(2'd2, rd);
    check("R7 received byte", rd, slV);
    check("R11 irq follows enable and flag", irq, ctrlV[7]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check("R1 register reset", rd, 8'h00);
    end
    check("R1 sclk reset", sclk, 1'b0);
    check("R1 mosi reset", mosi, 1'b0);
    check("R1 irq reset", irq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 control readback
    regWrite(2'd0, 8'hB7);
    regRead(2'd0, rd);
    check("R2 control readback", rd, 8'hB7);
    // main vector walk
    for (int v = 0; v < 6; v++) begin
      logic [21:0] e;
      e = VECS[v];
      xfer({1'b0, 1'b1, e[19], 1'b1, e[21], e[20], e[18:17]}, e[16], e[15:8], e[7:0], 1'b0);
    end
    // R9 collision mid-exchange, exchange undisturbed
    xfer(8'h51, 1'b0, 8'h6B, 8'hD4, 1'b1);
    // R10 next accepted write clears both flags (checked inside), R11 irq and ack
    xfer(8'hD0, 1'b1, 8'h2E, 8'h99, 1'b0);
    check("R11 irq raised", irq, 1'b1);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    regRead(2'd1, rd);
    check("R11 ack clears flag", rd[7], 1'b0);
    check("R11 irq dropped", irq, 1'b0);
    // R12 flag bits are not writable
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, rd);
    check("R12 status write", rd, 8'h01);
    regWrite(2'd1, 8'hC0);
    regRead(2'd1, rd);
    check("R12 status write clears dbl only", rd, 8'h00);
    // R8 write while disabled is ignored
    xfer(8'h48, 1'b0, 8'h33, 8'hA6, 1'b0);
    regWrite(2'd0, 8'h08);
    regWrite(2'd2, 8'h55);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk !== 1'b1) begin
        check("R8 sclk stays idle", sclk, 1'b1);
        break;
      end
    end
    regRead(2'd2, rd);
    check("R8 data unchanged", rd, 8'hA6);
    regRead(2'd1, rd);
    check("R8 status unchanged", rd, 8'h80);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule